// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Arbiter

This block decides which of several modules on one shared system bus owns the next bus cycle. Each module has one request line. The arbiter compares requests only at a cycle boundary, when the bus is idle. It then issues a single one-hot grant, chosen by a fixed priority order set by slot index. Slot 0 is the most urgent requester, for example a diagnostic port or the real-time-clock interrupt source. Burst devices come next, then display traffic. The primary general processor sits in the second-to-last slot, and an optional secondary processor takes the last slot so that it soaks up idle cycles.

The arbiter raises its own memory-refresh request every `RFR_INT` clocks, and refresh outranks every external slot. Once a cycle is granted, the grant stays in place until the addressed slave signals ready, so a fast slave (3 clocks) or a slow one (5 clocks) each sets its own cycle length. If no ready arrives within `TMO` clocks, the cycle is closed and flagged as a timeout. A requester that holds its lock line when it is granted receives a second cycle straight after the first, with no boundary and no other grant in between. This is what an atomic read-modify-write needs.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is active, and on the first clock after it, no grant, refresh grant, done or timeout output is asserted.
- R2: At most one of `gnt_o` and `rfr_gnt_o` is high in any clock.
- R3: At a boundary with no refresh pending, the requester with the lowest index in `req_i` wins. Bit 0 has the highest priority and bit N-1 the lowest.
- R4: A refresh request becomes pending every `RFR_INT` clocks after reset. A pending refresh wins the next boundary ahead of every requester, and the win clears it.
- R5: A grant stays unchanged for the whole cycle, whatever the requests do. The cycle ends on the clock edge where `slv_ready_i` is seen, so a cycle lasts exactly as many clocks as the slave takes to answer.
- R6: If `slv_ready_i` is not seen within `TMO` clocks (16 by default), the cycle ends after `TMO` clocks and `bus_tmo_o` is raised together with `bus_done_o`.
- R7: `bus_done_o` pulses for one clock after every cycle end. `bus_tmo_o` is low when the cycle ended on ready.
- R8: If the winning external requester has its `lock_i` bit high at the winning edge, it keeps its grant for a second cycle that starts on the very next clock. No other grant, and no refresh, comes between the two cycles. A refresh grant never pairs.
- R9: After any cycle that is not the first of a locked pair, all grants are low for exactly one clock (the boundary) before the next arbitration result shows.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N_REQ | Request line per slot, bit 0 most urgent |
| lock_i | input | N_REQ | Per-slot lock qualifier asking for a two-cycle atomic grant |
| slv_ready_i | input | 1 | Addressed slave finishes the current cycle |
| gnt_o | output | N_REQ | One-hot grant to the external slots |
| rfr_gnt_o | output | 1 | Grant of the current cycle to the internal refresh requester |
| bus_done_o | output | 1 | One-clock pulse after each cycle ends |
| bus_tmo_o | output | 1 | Raised with `bus_done_o` when the cycle ended by timeout |

## Verification
The embedded properties assume that a slave raises `slv_ready_i` only while some grant is active. They also assume a slave answers at most once per cycle. The bench honours both assumptions by modelling the slave from the grants it observes. The slave asserts ready in exactly the clock its chosen latency calls for (3 or 5 clocks), or never asserts it when a timeout is being exercised. It drops ready whenever no grant is active. Requests and lock bits are free to change on any clock. The design must ignore them except at a boundary, so the stimulus changes them at random mid-cycle on purpose.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bus_state_t;

  // True when a counter that starts at zero has spent a full period.
  function automatic logic period_last(input int unsigned count, input int unsigned period);
    return count == period - 1;
  endfunction

endpackage

// File: rtl/sba_refresh_timer.sv
module sba_refresh_timer #(
  parameter int unsigned RFR_INT = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served_i,
  output logic pend_o
);
  import sba_pkg::*;

  localparam int unsigned RW = (RFR_INT > 2) ? $clog2(RFR_INT) : 1;

  logic [RW-1:0] tick_q;
  logic          expire;

  assign expire = period_last(int'(tick_q), RFR_INT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_o <= 1'b0;
    end else begin
      tick_q <= expire ? '0 : tick_q + 1'b1;
      pend_o <= expire | (pend_o & ~served_i);
    end
  end

  // R4
  served_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    served_i |-> pend_o);

endmodule

// File: rtl/sba_prio_pick.sv
module sba_prio_pick #(
  parameter int unsigned W = 9
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] win_o
);
  logic [W-1:0] seen;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign win_o[i] = req_i[i];
      assign seen[i]  = req_i[i];
    end else begin : g_tail
      assign win_o[i] = req_i[i] & ~seen[i-1];
      assign seen[i]  = req_i[i] | seen[i-1];
    end
  end

  // R2
  always_comb begin
    pick_onehot_chk: assert ($onehot0(win_o));
  end

endmodule

// File: rtl/sba_cycle_timer.sv
module sba_cycle_timer #(
  parameter int unsigned TMO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic ready_i,
  output logic end_o,
  output logic tmo_o
);
  import sba_pkg::*;

  localparam int unsigned TW = (TMO > 2) ? $clog2(TMO) : 1;

  logic [TW-1:0] cnt_q;
  logic          limit;

  assign limit = period_last(int'(cnt_q), TMO);
  assign end_o = busy_i & (ready_i | limit);
  assign tmo_o = busy_i & limit & ~ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!busy_i || end_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R6
  cycle_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !end_o) |=> (cnt_q != '0));

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter #(
  parameter int unsigned N_REQ   = 8,
  parameter int unsigned RFR_INT = 256,
  parameter int unsigned TMO     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] lock_i,
  input  logic             slv_ready_i,
  output logic [N_REQ-1:0] gnt_o,
  output logic             rfr_gnt_o,
  output logic             bus_done_o,
  output logic             bus_tmo_o
);
  import sba_pkg::*;

  localparam int unsigned NS = N_REQ + 1;  // slot 0 is refresh

  bus_state_t    state_q;
  logic [NS-1:0] own_q;
  logic          pair_q;
  logic          rfr_pend;
  logic [NS-1:0] all_req;
  logic [NS-1:0] pick;
  logic          busy;
  logic          arb_fire;
  logic          cyc_end;
  logic          cyc_tmo;
  logic          rfr_served;

  assign all_req    = {req_i, rfr_pend};
  assign busy       = (state_q == ST_BUSY);
  assign arb_fire   = (state_q == ST_IDLE) && (|all_req);
  assign rfr_served = arb_fire & pick[0];

  sba_refresh_timer #(.RFR_INT(RFR_INT)) u_rfr (
    .clk(clk), .rst_n(rst_n), .served_i(rfr_served), .pend_o(rfr_pend)
  );

  sba_prio_pick #(.W(NS)) u_pick (
    .req_i(all_req), .win_o(pick)
  );

  sba_cycle_timer #(.TMO(TMO)) u_tim (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .ready_i(slv_ready_i),
    .end_o(cyc_end), .tmo_o(cyc_tmo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      own_q      <= '0;
      pair_q     <= 1'b0;
      bus_done_o <= 1'b0;
      bus_tmo_o  <= 1'b0;
    end else begin
      bus_done_o <= cyc_end;
      bus_tmo_o  <= cyc_tmo;
      if (arb_fire) begin
        state_q <= ST_BUSY;
        own_q   <= pick;
        pair_q  <= |(pick[NS-1:1] & lock_i);
      end else if (cyc_end) begin
        if (pair_q) begin
          pair_q <= 1'b0;
        end else begin
          state_q <= ST_IDLE;
          own_q   <= '0;
        end
      end
    end
  end

  assign rfr_gnt_o = own_q[0];
  assign gnt_o     = own_q[NS-1:1];

  // R2
  onehot_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gnt_o, rfr_gnt_o}));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_end) |=> $stable({gnt_o, rfr_gnt_o}));

  // R4
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_fire && rfr_pend) |=> rfr_gnt_o);

  // R8
  lock_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && pair_q) |=> ($stable(gnt_o) && (gnt_o != '0) && bus_done_o));

  // R6
  tmo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tmo_o |-> (bus_done_o && !$past(slv_ready_i)));

  // R9
  boundary_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !pair_q) |=> ({gnt_o, rfr_gnt_o} == '0));

  // Input assumption: a slave answers only inside a granted cycle.
  ready_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ready_i |-> busy);

endmodule

// File: tb/shared_bus_arbiter_tb.sv
module shared_bus_arbiter_tb;
  localparam int N   = 8;
  localparam int RI  = 40;
  localparam int TO  = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] lock = '0;
  logic         ready = 1'b0;
  logic [N-1:0] gnt;
  logic         rfr;
  logic         done;
  logic         tmo;

  shared_bus_arbiter #(.N_REQ(N), .RFR_INT(RI), .TMO(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .slv_ready_i(ready),
    .gnt_o(gnt), .rfr_gnt_o(rfr), .bus_done_o(done), .bus_tmo_o(tmo)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int np = 0;

  always @(posedge clk) if (rst_n) np <= np + 1;

  // bench state
  logic [N:0]   owner = '0;
  logic [N-1:0] prev_req = '0;
  logic [N-1:0] prev_lock = '0;
  bit           prev_any = 0;
  bit           mp = 0;
  bit           pair_first = 0;
  int           len = 0;
  int           slat = 3;
  int           forced = -1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N:0] expect_win(input logic [N-1:0] r, input bit pend);
    logic [N:0] all = {r, pend};
    for (int i = 0; i <= N; i++) if (all[i]) return (N+1)'(1) << i;
    return '0;
  endfunction

  function automatic int pick_lat();
    int v = int'($urandom_range(0, 9));
    if (forced >= 0) return forced;
    if (v == 0) return 0;
    return (v < 6) ? 3 : 5;
  endfunction

  function automatic int expect_len(input int lat);
    return (lat == 0) ? TO : lat;
  endfunction

  task automatic step();
    logic [N:0] cur = {gnt, rfr};
    bit any_now = |cur;
    bit old_mp = mp;
    // R2
    chk($countones(cur) <= 1, "R2 onehot", 32'(cur), 32'(owner));
    if (done) begin
      // R5 cycle length follows slave latency; R6 timeout length
      chk(len == expect_len(slat), "R5/R6 cycle length", len, expect_len(slat));
      // R7 timeout flag only on timeout
      chk(tmo == (slat == 0), "R7 tmo flag", 32'(tmo), 32'(slat == 0));
      if (pair_first) begin
        // R8 locked second cycle follows at once
        chk(cur == owner, "R8 locked pair", 32'(cur), 32'(owner));
        pair_first = 0;
      end else begin
        // R9 one boundary clock with no grant
        chk(cur == '0, "R9 boundary gap", 32'(cur), 0);
      end
      len = 0;
    end else begin
      if (prev_any) chk(cur == owner, "R5 grant held", 32'(cur), 32'(owner));
      chk(tmo == 1'b0, "R7 tmo without done", 32'(tmo), 0);
    end
    if (!prev_any && any_now) begin
      logic [N:0] ex = expect_win(prev_req, old_mp);
      // R3 fixed priority, R4 refresh first
      chk(cur == ex, ex[0] ? "R4 refresh wins" : "R3 priority", 32'(cur), 32'(ex));
      owner = cur;
      pair_first = !cur[0] && (|(cur[N:1] & prev_lock));
    end
    if ((np % RI) == 0 && np != 0) mp = 1;
    else if (!prev_any && any_now && cur[0]) mp = 0;
    if (any_now) begin
      if (len == 0) slat = pick_lat();
      len++;
      ready = (slat != 0) && (len == slat);
    end else begin
      ready = 1'b0;
    end
    prev_any = any_now;
  endtask

  task automatic drive(input logic [N-1:0] r, input logic [N-1:0] l);
    req = r;
    lock = l;
    prev_req = r;
    prev_lock = l;
  endtask

  function automatic logic [N-1:0] sparse();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ($urandom_range(0, 3) == 0);
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({gnt, rfr, done, tmo} == '0, "R1 reset outputs", 32'({gnt, rfr, done, tmo}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({gnt, rfr, done, tmo} == '0, "R1 first clock", 32'({gnt, rfr, done, tmo}), 0);
    for (int c = 0; c < 6000; c++) begin
      step();
      if (c < 200) begin
        forced = 3; drive('1, '0);                    // R3 everyone requests
      end else if (c < 400) begin
        forced = 5; drive(N'(1) << (N-1), '0);        // R3 lowest slot alone
      end else if (c < 600) begin
        forced = 0; drive(8'h10, '0);                 // R6 no slave answer
      end else if (c < 800) begin
        forced = 3; drive(8'h04, 8'h04);              // R8 locked pairs
      end else begin
        forced = -1;
        if ($urandom_range(0, 3) == 0) drive(sparse(), sparse());
      end
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule